// File: doc/BRIEF.md
# Priority Crossbar Arbiter with Per-Slave Round-Robin

This block is the routing and arbitration core of a shared-bus crossbar that links a set of bus masters to a set of bus slaves using the Wishbone handshake (cyc, stb, we, sel, address, write data, read data, ack, err, rty). Each master picks its target with the four most significant address bits. Every slave port has its own small arbiter, so masters heading for different slaves are served in the same cycles.

When several masters want the same free slave, the master whose 2-bit priority field in `prio_cfg` is largest wins. Ties among the top priority level are broken by a rotating pointer kept per slave. Once a master owns a slave it keeps it as long as its cyc stays high, through wait cycles with stb low and across any number of transfers ended by ack, err or rty. Dropping cyc frees the slave.

Each slave arbiter is a two-state machine. `ARB_FREE`: no owner, the slave sees cyc and stb low; the transition *claim* fires on a clock edge where at least one eligible master requests this slave, recording the winner. `ARB_HELD`: the owner's signals are routed; the transition *release* fires on an edge where the owner's cyc is low, moving the rotating pointer to the master after the owner. In `ARB_HELD` with cyc still high the machine stays put (*hold*); in `ARB_FREE` with no requester it stays put (*wait*).

Top module: `prio_xbar`

## Requirements
- R1: A master with cyc high targets the slave numbered by `m_adr[31:28]`; a value of NS or above reaches no slave.
- R2: A request sampled at a clock edge by a free slave makes that slave's cyc rise just after that edge, never in the cycle the request first appears.
- R3: Master m's priority is `prio_cfg[2m+1:2m]`; among masters requesting a free slave, one with the largest value is granted.
- R4: Among requesters sharing the top priority, the grant goes to the first in ascending order starting at the slave's pointer, wrapping; the pointer is 0 after reset and becomes owner+1 (mod NM) when the owner releases.
- R5: An owner keeps its slave while its cyc is high, also while its stb is low; other requests to that slave wait, whatever their priority.
- R6: An owned slave receives the owner's cyc, stb, we, sel, address and write data unchanged.
- R7: The owner receives its slave's ack, err, rty and read data; a master that owns no slave sees ack, err and rty low.
- R8: A slave with no owner sees cyc and stb low.
- R9: Reset clears every grant.
- R10: A master owns at most one slave, and a slave has at most one owner; different slaves serve different masters at the same time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prio_cfg | input | 2*NM | Per-master 2-bit priority, master m in bits 2m+1:2m |
| m_cyc | input | NM | Master bus-cycle request |
| m_stb | input | NM | Master data-phase strobe |
| m_we | input | NM | Master write enable |
| m_sel | input | NM*DW/8 | Master byte-lane selects |
| m_adr | input | NM*AW | Master addresses |
| m_wdat | input | NM*DW | Master write data |
| m_rdat | output | NM*DW | Read data back to each master |
| m_ack | output | NM | Acknowledge back to each master |
| m_err | output | NM | Error back to each master |
| m_rty | output | NM | Retry back to each master |
| s_cyc | output | NS | Cycle to each slave |
| s_stb | output | NS | Strobe to each slave |
| s_we | output | NS | Write enable to each slave |
| s_sel | output | NS*DW/8 | Byte-lane selects to each slave |
| s_adr | output | NS*AW | Address to each slave |
| s_wdat | output | NS*DW | Write data to each slave |
| s_rdat | input | NS*DW | Read data from each slave |
| s_ack | input | NS | Acknowledge from each slave |
| s_err | input | NS | Error from each slave |
| s_rty | input | NS | Retry from each slave |

## Verification
The bench builds the block with four masters and four slaves, 32-bit address and data. With only four slaves, address nibbles from 4 upward fall outside the map, so the no-target case of R1 can be driven, and four masters are enough to create a three-way tie that walks the rotating pointer through a wrap back to master 0. A slave kept idle until the rotation test guarantees its pointer is still at its reset value.

// File: rtl/prio_xbar_pkg.sv
package prio_xbar_pkg;
    localparam int PRIO_W = 2;
    localparam int SEL_MSB_W = 4;

    typedef enum logic {
        ARB_FREE = 1'b0,
        ARB_HELD = 1'b1
    } arb_state_t;
endpackage

// File: rtl/prio_xbar_pick.sv
module prio_xbar_pick #(
    parameter int NM = 8,
    localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic [NM-1:0]   req,
    input  logic [2*NM-1:0] prio,
    input  logic [IW-1:0]   ptr,
    output logic            found,
    output logic [IW-1:0]   win
);
    logic [1:0]    top_lvl;
    logic [NM-1:0] cand;

    // level 1: highest priority among requesters
    always_comb begin
        top_lvl = 2'd0;
        for (int m = 0; m < NM; m++) begin
            if (req[m] && prio[2*m +: 2] > top_lvl) top_lvl = prio[2*m +: 2];
        end
        for (int m = 0; m < NM; m++) begin
            cand[m] = req[m] && (prio[2*m +: 2] == top_lvl);
        end
    end

    // level 2: first candidate at or after the pointer, wrapping
    always_comb begin
        found = 1'b0;
        win   = '0;
        for (int k = 0; k < NM; k++) begin
            int j;
            j = int'(ptr) + k;
            if (j >= NM) j = j - NM;
            if (!found && cand[j]) begin
                found = 1'b1;
                win   = IW'(j);
            end
        end
    end
endmodule

// File: rtl/prio_xbar_slot.sv
module prio_xbar_slot
    import prio_xbar_pkg::*;
#(
    parameter int NM = 8,
    localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NM-1:0]   req,
    input  logic [NM-1:0]   cyc,
    input  logic [2*NM-1:0] prio,
    output logic [NM-1:0]   grant,
    output logic [IW-1:0]   owner,
    output logic            held
);
    arb_state_t    state_q;
    logic [IW-1:0] owner_q;
    logic [IW-1:0] ptr_q;
    logic          pick_ok;
    logic [IW-1:0] pick_idx;

    prio_xbar_pick #(.NM(NM)) u_pick (
        .req   (req),
        .prio  (prio),
        .ptr   (ptr_q),
        .found (pick_ok),
        .win   (pick_idx)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_FREE;
            owner_q <= '0;
            ptr_q   <= '0;
        end else begin
            unique case (state_q)
                ARB_FREE: begin
                    if (pick_ok) begin
                        state_q <= ARB_HELD;
                        owner_q <= pick_idx;
                    end
                end
                ARB_HELD: begin
                    if (!cyc[owner_q]) begin
                        state_q <= ARB_FREE;
                        ptr_q   <= (int'(owner_q) == NM - 1) ? '0 : owner_q + 1'b1;
                    end
                end
                default: state_q <= ARB_FREE;
            endcase
        end
    end

    always_comb begin
        grant = '0;
        held  = 1'b0;
        owner = owner_q;
        unique case (state_q)
            ARB_FREE: held = 1'b0;
            ARB_HELD: begin
                held           = 1'b1;
                grant[owner_q] = 1'b1;
            end
            default: held = 1'b0;
        endcase
    end
endmodule

// File: rtl/prio_xbar.sv
module prio_xbar
    import prio_xbar_pkg::*;
#(
    parameter int NM = 8,
    parameter int NS = 16,
    parameter int AW = 32,
    parameter int DW = 32,
    localparam int SW = DW / 8,
    localparam int IW = (NM > 1) ? $clog2(NM) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2*NM-1:0] prio_cfg,
    input  logic [NM-1:0]   m_cyc,
    input  logic [NM-1:0]   m_stb,
    input  logic [NM-1:0]   m_we,
    input  logic [NM*SW-1:0] m_sel,
    input  logic [NM*AW-1:0] m_adr,
    input  logic [NM*DW-1:0] m_wdat,
    output logic [NM*DW-1:0] m_rdat,
    output logic [NM-1:0]   m_ack,
    output logic [NM-1:0]   m_err,
    output logic [NM-1:0]   m_rty,
    output logic [NS-1:0]   s_cyc,
    output logic [NS-1:0]   s_stb,
    output logic [NS-1:0]   s_we,
    output logic [NS*SW-1:0] s_sel,
    output logic [NS*AW-1:0] s_adr,
    output logic [NS*DW-1:0] s_wdat,
    input  logic [NS*DW-1:0] s_rdat,
    input  logic [NS-1:0]   s_ack,
    input  logic [NS-1:0]   s_err,
    input  logic [NS-1:0]   s_rty
);
    logic [NS-1:0][NM-1:0] grant;
    logic [NS-1:0][NM-1:0] req;
    logic [NS-1:0][IW-1:0] owner;
    logic [NS-1:0]         held;
    logic [NM-1:0]         m_owns;

    // a master already linked somewhere may not claim a second slave
    always_comb begin
        m_owns = '0;
        for (int s = 0; s < NS; s++) m_owns = m_owns | grant[s];
    end

    for (genvar s = 0; s < NS; s++) begin : g_slave
        always_comb begin
            for (int m = 0; m < NM; m++) begin
                req[s][m] = m_cyc[m] && !m_owns[m] &&
                            (m_adr[m*AW + AW - SEL_MSB_W +: SEL_MSB_W] == SEL_MSB_W'(s));
            end
        end

        prio_xbar_slot #(.NM(NM)) u_slot (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req[s]),
            .cyc   (m_cyc),
            .prio  (prio_cfg),
            .grant (grant[s]),
            .owner (owner[s]),
            .held  (held[s])
        );

        always_comb begin
            s_cyc[s]           = held[s] && m_cyc[owner[s]];
            s_stb[s]           = held[s] && m_stb[owner[s]];
            s_we[s]            = held[s] && m_we[owner[s]];
            s_sel[s*SW +: SW]  = held[s] ? m_sel[owner[s]*SW +: SW] : '0;
            s_adr[s*AW +: AW]  = held[s] ? m_adr[owner[s]*AW +: AW] : '0;
            s_wdat[s*DW +: DW] = held[s] ? m_wdat[owner[s]*DW +: DW] : '0;
        end
    end

    for (genvar m = 0; m < NM; m++) begin : g_master
        always_comb begin
            m_ack[m]           = 1'b0;
            m_err[m]           = 1'b0;
            m_rty[m]           = 1'b0;
            m_rdat[m*DW +: DW] = '0;
            for (int s = 0; s < NS; s++) begin
                if (grant[s][m]) begin
                    m_ack[m]           = s_ack[s];
                    m_err[m]           = s_err[s];
                    m_rty[m]           = s_rty[s];
                    m_rdat[m*DW +: DW] = s_rdat[s*DW +: DW];
                end
            end
        end
    end
endmodule

// File: rtl/prio_xbar_chk.sv
module prio_xbar_chk #(
    parameter int NM = 8,
    parameter int NS = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NM-1:0]         m_cyc,
    input logic [NM-1:0]         m_ack,
    input logic [NM-1:0]         m_err,
    input logic [NM-1:0]         m_rty,
    input logic [NS-1:0]         s_cyc,
    input logic [NS-1:0][NM-1:0] grant
);
    logic [NM-1:0][NS-1:0] col;

    always_comb begin
        for (int m = 0; m < NM; m++)
            for (int s = 0; s < NS; s++)
                col[m][s] = grant[s][m];
    end

    for (genvar s = 0; s < NS; s++) begin : g_s
        a_r10_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(grant[s]));
        a_r8_free_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !(|grant[s]) |-> !s_cyc[s]);
        for (genvar m = 0; m < NM; m++) begin : g_m
            a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (grant[s][m] && m_cyc[m]) |=> grant[s][m]);
            a_r2_claim_needs_cyc: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(grant[s][m]) |-> $past(m_cyc[m]));
        end
    end

    for (genvar m = 0; m < NM; m++) begin : g_mm
        a_r10_one_slave: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(col[m]));
        a_r7_unlinked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !(|col[m]) |-> !(m_ack[m] || m_err[m] || m_rty[m]));
    end
endmodule

bind prio_xbar prio_xbar_chk #(.NM(NM), .NS(NS)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .m_cyc (m_cyc),
    .m_ack (m_ack),
    .m_err (m_err),
    .m_rty (m_rty),
    .s_cyc (s_cyc),
    .grant (grant)
);

// File: tb/prio_xbar_test.sv
`timescale 1ns/1ps
module prio_xbar_test;
    localparam int NM = 4, NS = 4, AW = 32, DW = 32, SW = DW / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2*NM-1:0]  prio_cfg = '0;
    logic [NM-1:0]    m_cyc = '0, m_stb = '0, m_we = '0;
    logic [NM*SW-1:0] m_sel = '0;
    logic [NM*AW-1:0] m_adr = '0;
    logic [NM*DW-1:0] m_wdat = '0;
    logic [NM*DW-1:0] m_rdat;
    logic [NM-1:0]    m_ack, m_err, m_rty;
    logic [NS-1:0]    s_cyc, s_stb, s_we;
    logic [NS*SW-1:0] s_sel;
    logic [NS*AW-1:0] s_adr;
    logic [NS*DW-1:0] s_wdat;
    logic [NS*DW-1:0] s_rdat = '0;
    logic [NS-1:0]    s_ack = '0, s_err = '0, s_rty = '0;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    prio_xbar #(.NM(NM), .NS(NS), .AW(AW), .DW(DW)) uut (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic drive(int m, bit cyc, bit stb, bit we, logic [31:0] adr,
                         logic [31:0] dat, logic [3:0] sel);
        m_cyc[m] = cyc;
        m_stb[m] = stb;
        m_we[m]  = we;
        m_adr[m*AW +: AW]  = adr;
        m_wdat[m*DW +: DW] = dat;
        m_sel[m*SW +: SW]  = sel;
    endtask

    task automatic clear_all();
        @(negedge clk);
        m_cyc = '0; m_stb = '0; m_we = '0; m_sel = '0; m_adr = '0; m_wdat = '0;
        s_ack = '0; s_err = '0; s_rty = '0; s_rdat = '0;
        step();
        step();
    endtask

    task automatic t_reset();
        step();
        check("R9 slave cyc in reset", 32'(s_cyc), 32'h0);
        check("R9 master ack in reset", 32'(m_ack), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        step();
    endtask

    task automatic t_route();
        @(negedge clk);
        drive(1, 1, 1, 1, 32'h2000_0044, 32'hA5A5_0001, 4'b0011);
        #1;
        check("R2 no link in request cycle", 32'(s_cyc), 32'h0);
        step();
        check("R1 R2 slave 2 linked", 32'(s_cyc), 32'h4);
        check("R6 address", s_adr[2*AW +: AW], 32'h2000_0044);
        check("R6 write data", s_wdat[2*DW +: DW], 32'hA5A5_0001);
        check("R6 sel", 32'(s_sel[2*SW +: SW]), 32'h3);
        check("R6 we stb", 32'({s_we[2], s_stb[2]}), 32'h3);
        @(negedge clk);
        s_ack[2] = 1'b1;
        s_rdat[2*DW +: DW] = 32'h1234_5678;
        s_err[0] = 1'b1;
        #1;
        check("R7 ack to owner only", 32'(m_ack), 32'h2);
        check("R7 read data", m_rdat[1*DW +: DW], 32'h1234_5678);
        check("R7 err from unowned slave", 32'(m_err), 32'h0);
        @(negedge clk);
        s_ack = '0; s_err = '0;
        m_cyc[1] = 1'b0; m_stb[1] = 1'b0;
        step();
        check("R8 released slave quiet", 32'({s_cyc, s_stb}), 32'h0);
        clear_all();
    endtask

    task automatic t_unmapped();
        @(negedge clk);
        drive(0, 1, 1, 0, 32'h5000_0000, 32'h0, 4'hF);
        step();
        step();
        check("R1 nibble beyond map", 32'(s_cyc), 32'h0);
        clear_all();
    endtask

    task automatic t_prio();
        @(negedge clk);
        prio_cfg = 8'b00_11_00_01;  // m2=3, m0=1
        drive(0, 1, 1, 0, 32'h1000_0000, 32'h0, 4'hF);
        drive(2, 1, 1, 0, 32'h1000_0020, 32'h0, 4'hF);
        step();
        check("R3 higher priority wins", s_adr[1*AW +: AW], 32'h1000_0020);
        @(negedge clk);
        m_cyc[2] = 1'b0; m_stb[2] = 1'b0;
        step();
        step();
        check("R3 lower priority after release", s_adr[1*AW +: AW], 32'h1000_0000);
        clear_all();
    endtask

    task automatic t_hold();
        @(negedge clk);
        prio_cfg = 8'b11_00_00_00;  // m3=3
        drive(0, 1, 1, 1, 32'h2000_0000, 32'hDEAD_0000, 4'hF);
        step();
        @(negedge clk);
        m_stb[0] = 1'b0;
        drive(3, 1, 1, 1, 32'h2000_0030, 32'h0, 4'hF);
        step();
        step();
        step();
        check("R5 held through wait", s_adr[2*AW +: AW], 32'h2000_0000);
        check("R5 stb low cyc high", 32'({s_cyc[2], s_stb[2]}), 32'h2);
        @(negedge clk);
        m_stb[0] = 1'b1;
        s_ack[2] = 1'b1;
        #1;
        check("R5 waiting master sees no ack", 32'(m_ack), 32'h1);
        clear_all();
    endtask

    task automatic t_rr();
        int exp_order[4] = '{0, 1, 3, 0};
        @(negedge clk);
        prio_cfg = '0;
        for (int m = 0; m < NM; m++)
            if (m != 2) drive(m, 1, 1, 0, 32'h3000_0000 | (m << 4), 32'h0, 4'hF);
        step();
        for (int i = 0; i < 4; i++) begin
            int own;
            own = exp_order[i];
            check($sformatf("R4 rotation step %0d", i), s_adr[3*AW +: AW],
                  32'h3000_0000 | (own << 4));
            @(negedge clk);
            m_cyc[own] = 1'b0;
            step();
            check("R8 free between owners", 32'(s_cyc[3]), 32'h0);
            @(negedge clk);
            m_cyc[own] = 1'b1;
            step();
        end
        clear_all();
    endtask

    task automatic t_parallel();
        @(negedge clk);
        drive(0, 1, 1, 0, 32'h0000_0000, 32'h0, 4'hF);
        drive(1, 1, 1, 0, 32'h1000_0010, 32'h0, 4'hF);
        step();
        check("R10 two slaves at once", 32'(s_cyc), 32'h3);
        @(negedge clk);
        s_ack = 4'b0010;
        s_rty = 4'b0001;
        #1;
        check("R10 ack to master 1 only", 32'(m_ack), 32'h2);
        check("R7 R10 rty to master 0 only", 32'(m_rty), 32'h1);
        clear_all();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  %0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_route();
        t_unmapped();
        t_prio();
        t_hold();
        t_rr();
        t_parallel();
        done = 1'b1;
        $display("  %0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule